// File: doc/BRIEF.md
# Per-line edge-detect interrupt capture

This block watches the lower 24 lines of a 48-line general-purpose I/O bank and turns selected transitions on them into latched interrupt flags. Each watched line has its own polarity bit, which picks the rising or the falling transition, and its own enable bit. A qualifying transition on an enabled line sets that line's bit in one of three 8-bit capture registers, one per group of eight lines. The upper 24 lines are accepted at the input but can never raise anything.

The host clears a capture register by writing the value zero to it through a decoded write strobe. A 3-bit summary shows which capture registers hold any set bit. A single registered request output is raised whenever the summary is non-zero. Paging, address decoding and the pin synchronizers sit outside the block; it receives already-synchronized pin levels and decoded strobes.

Top module: `edge_irq_capture`

## Requirements
- R1: With a line's polarity bit at 1, a low-to-high change of that line's level between two consecutive clock edges sets its capture bit at the second edge.
- R2: With a line's polarity bit at 0, a high-to-low change of that line's level between two consecutive clock edges sets its capture bit at the second edge.
- R3: A line whose enable bit is 0 never sets its capture bit, in either direction.
- R4: A set capture bit stays set, with no further edges, until a clearing write to its register.
- R5: Bit p of `pending` is 1 exactly when capture register p (bits 8p+7..8p of `int_id`) has any bit set.
- R6: A write strobe `clr_wr[p]` with `clr_data` equal to zero clears capture register p at that clock edge; a strobe with non-zero data leaves the register unchanged.
- R7: `irq` equals the OR of the `pending` bits as they stood one clock earlier.
- R8: A qualifying edge that arrives in the same cycle as a clearing write to its register keeps its bit set; other bits of that register are cleared.
- R9: Dropping an enable bit does not clear a capture bit that is already set.
- R10: Changing a polarity bit while the line level is steady sets no capture bit.
- R11: Lines 24 to 47 never set any capture bit and never affect `pending` or `irq`.
- R12: During reset `int_id`, `pending` and `irq` are zero, and the first clock edge after reset is released sets no capture bit whatever the line levels are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | 48 | Synchronized levels of all I/O lines |
| polarity | input | 24 | Per-line edge select, 1 = rising, 0 = falling |
| enable | input | 24 | Per-line capture enable |
| clr_wr | input | 3 | Decoded write strobe, one per capture register |
| clr_data | input | 8 | Data accompanying a capture-register write |
| int_id | output | 24 | Capture registers, register p in bits 8p+7..8p |
| pending | output | 3 | Per-register non-empty summary |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a clearing write that lands in the very cycle a new edge qualifies on the same register, together with other already-latched bits that must go. Directed steps first latch bits in one register, then drive a zero write and a fresh edge on another line of that register in the same cycle. Random phases with a low write probability and dense pin toggling revisit the collision many times more, including writes with non-zero data and enables dropping under latched bits.

// File: rtl/eic_pkg.sv
// Shared constants for the edge-detect interrupt capture block.
// Assumes a bank of byte-wide ports where only the lowest few ports
// carry edge detection.
package eic_pkg;
    localparam int EIC_PORT_W    = 8;
    localparam int EIC_IRQ_PORTS = 3;
    localparam int EIC_ALL_LINES = 48;

    // Number of lines that carry edge detection
    function automatic int eic_irq_lines(input int ports, input int width);
        return ports * width;
    endfunction
endpackage

// File: rtl/eic_edge_detect.sv
// Per-line edge qualifier. Compares each line with its level one clock
// earlier and reports an enabled edge of the selected direction.
// Assumes levels are already synchronized. Suppresses detection on the
// first clock after reset, when no earlier level is known.
module eic_edge_detect #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] polarity,
    input  logic [N-1:0] enable,
    output logic [N-1:0] hit
);
    logic         armed;
    logic [N-1:0] prev;

    // Hold the previous level and note that it is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            prev  <= '0;
        end else begin
            armed <= 1'b1;
            prev  <= level;
        end
    end

    // Qualify each line's transition by direction and enable
    for (genvar i = 0; i < N; i++) begin : g_line
        logic rise, fall;
        always_comb begin
            rise   = level[i] & ~prev[i];
            fall   = ~level[i] & prev[i];
            hit[i] = armed & enable[i] & (polarity[i] ? rise : fall);
        end
    end
endmodule

// File: rtl/eic_id_port.sv
// One capture register. Sets bits on qualified edges, clears on a write
// of zero, and lets an edge in the clearing cycle survive.
// Assumes the strobe is a single-cycle decoded write.
module eic_id_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] id,
    output logic         pend
);
    logic clr_now;

    // A write clears only when its data is zero
    always_comb clr_now = clr_wr && (clr_data == '0);

    // Latch edges, clearing on request with edges taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)       id <= '0;
        else if (clr_now) id <= hit;
        else              id <= id | hit;
    end

    // Register is non-empty
    always_comb pend = |id;
endmodule

// File: rtl/eic_irq_out.sv
// Request generator: registers the OR of the per-register summary.
module eic_irq_out #(
    parameter int P = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [P-1:0] pend,
    output logic         irq
);
    // Register the combined summary
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end
endmodule

// File: rtl/edge_irq_capture.sv
// Top of the edge-detect interrupt capture block. Lines above the
// detecting ports are accepted and ignored. Register paging and address
// decode are outside; writes arrive as per-register strobes.
module edge_irq_capture #(
    parameter int NUM_PORTS = eic_pkg::EIC_IRQ_PORTS,
    parameter int PORT_W    = eic_pkg::EIC_PORT_W,
    parameter int NUM_LINES = eic_pkg::EIC_ALL_LINES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           pin_level,
    input  logic [NUM_PORTS*PORT_W-1:0]    polarity,
    input  logic [NUM_PORTS*PORT_W-1:0]    enable,
    input  logic [NUM_PORTS-1:0]           clr_wr,
    input  logic [PORT_W-1:0]              clr_data,
    output logic [NUM_PORTS*PORT_W-1:0]    int_id,
    output logic [NUM_PORTS-1:0]           pending,
    output logic                           irq
);
    localparam int IRQ_LINES = eic_pkg::eic_irq_lines(NUM_PORTS, PORT_W);

    logic [IRQ_LINES-1:0] hit;
    logic                 unused_upper;

    // Upper lines carry no detection
    always_comb unused_upper = ^pin_level[NUM_LINES-1:IRQ_LINES];

    eic_edge_detect #(.N(IRQ_LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_level[IRQ_LINES-1:0]),
        .polarity (polarity),
        .enable   (enable),
        .hit      (hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        eic_id_port #(.W(PORT_W)) u_id (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[p*PORT_W +: PORT_W]),
            .clr_wr   (clr_wr[p]),
            .clr_data (clr_data),
            .id       (int_id[p*PORT_W +: PORT_W]),
            .pend     (pending[p])
        );
    end

    eic_irq_out #(.P(NUM_PORTS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pending),
        .irq   (irq)
    );
endmodule

// File: rtl/eic_checker.sv
// Temporal checks on the capture block, attached through bind.
module eic_checker #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS*PORT_W-1:0] enable,
    input logic [NUM_PORTS-1:0]        clr_wr,
    input logic [PORT_W-1:0]           clr_data,
    input logic [NUM_PORTS*PORT_W-1:0] int_id,
    input logic [NUM_PORTS-1:0]        pending,
    input logic                        irq
);
    logic started = 1'b0;

    // Mark that one clean clock edge has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (int_id == '0 && !irq)); // R12
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (started && clr_wr == '0) |=> ((int_id & $past(int_id)) == $past(int_id))); // R4
    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> ((int_id & ~$past(int_id) & ~$past(enable)) == '0)); // R3
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pending != '0) |=> irq); // R7
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pending == '0) |=> !irq); // R7

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_clr
        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (started && clr_wr[p] && clr_data == '0 && enable[p*PORT_W +: PORT_W] == '0)
            |=> (int_id[p*PORT_W +: PORT_W] == '0)); // R6
    end
endmodule

bind edge_irq_capture eic_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_eic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .int_id   (int_id),
    .pending  (pending),
    .irq      (irq)
);

// File: tb/test_edge_irq_capture.sv
module test_edge_irq_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] pin_level;
    logic [23:0] polarity, enable;
    logic [2:0]  clr_wr;
    logic [7:0]  clr_data;
    logic [23:0] int_id;
    logic [2:0]  pending;
    logic        irq;

    int checks = 0, failures = 0;

    // Bench model state
    bit        m_armed;
    bit [23:0] m_prev, m_id;
    bit        m_irq;

    always #10 clk = ~clk;

    edge_irq_capture i_edge_irq_capture (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .polarity(polarity),
        .enable(enable), .clr_wr(clr_wr), .clr_data(clr_data),
        .int_id(int_id), .pending(pending), .irq(irq)
    );

    function automatic bit [2:0] summ(input bit [23:0] id);
        return {|id[23:16], |id[15:8], |id[7:0]};
    endfunction

    function automatic bit [23:0] hits(input bit [23:0] lvl, input bit [23:0] prv,
                                       input bit [23:0] pol, input bit [23:0] en, input bit arm);
        bit [23:0] r = (pol & lvl & ~prv) | (~pol & ~lvl & prv);
        return arm ? (r & en) : 24'h0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the next falling edge
    task automatic cycle(input string tag);
        bit [23:0] h;
        @(posedge clk);
        if (!rst_n) begin
            m_armed = 0; m_prev = '0; m_id = '0; m_irq = 0;
        end else begin
            m_irq = |m_id;
            h = hits(pin_level[23:0], m_prev, polarity, enable, m_armed);
            for (int p = 0; p < 3; p++) begin
                if (clr_wr[p] && clr_data == 8'h00) m_id[p*8 +: 8] = h[p*8 +: 8];
                else                                 m_id[p*8 +: 8] = m_id[p*8 +: 8] | h[p*8 +: 8];
            end
            m_armed = 1; m_prev = pin_level[23:0];
        end
        @(negedge clk);
        chk(tag, "int_id", int_id, m_id);
        chk(tag, "pending", pending, summ(m_id));
        chk(tag, "irq", irq, m_irq);
        clr_wr = '0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; pin_level = '1; polarity = '1; enable = '1; clr_wr = '0; clr_data = '0;
        repeat (2) cycle("R12 reset");
        // First edge after reset: lines high against a zero history, no capture
        @(negedge clk); rst_n = 1;
        cycle("R12 first edge");
        if (int_id != 0) $display("note: first-edge capture seen");
        // R1 rising on line 3
        pin_level[3] = 0; cycle("R1 setup");
        pin_level[3] = 1; cycle("R1 rise");
        // R2 falling on line 10 with polarity 0
        polarity[10] = 0; pin_level[10] = 0; cycle("R2 fall");
        // R3 disabled line 17 both ways
        enable[17] = 0; polarity[17] = 1; pin_level[17] = 0; cycle("R3 low");
        pin_level[17] = 1; cycle("R3 high");
        // R4 hold across idle cycles, R5 summary observed
        repeat (3) cycle("R4 hold R5");
        // R6 non-zero write has no effect, zero write clears
        clr_wr = 3'b001; clr_data = 8'h5a; cycle("R6 nonzero");
        clr_wr = 3'b001; clr_data = 8'h00; cycle("R6 zero");
        // R8 clear of port 1 while line 9 rises; line 10 bit must go
        polarity[9] = 1; pin_level[9] = 0; cycle("R8 setup");
        pin_level[9] = 1; clr_wr = 3'b010; clr_data = 8'h00; cycle("R8 collide");
        // R9 latch line 20 then drop its enable
        polarity[20] = 1; pin_level[20] = 0; cycle("R9 setup");
        pin_level[20] = 1; cycle("R9 latch");
        enable[20] = 0; repeat (2) cycle("R9 kept");
        // R10 flip polarity with steady levels after clearing all
        clr_wr = 3'b111; clr_data = 8'h00; cycle("R10 clear");
        polarity = ~polarity; cycle("R10 flip");
        polarity = ~polarity; cycle("R10 flip back");
        // R11 upper lines toggle
        pin_level[47:24] = ~pin_level[47:24]; cycle("R11 toggle");
        pin_level[47:24] = 24'h000000; cycle("R11 low");
        // R7 irq tracks summary after clearing
        clr_wr = 3'b111; clr_data = 8'h00; cycle("R7 clear");
        cycle("R7 drop");
        // Random mix, tags R1 R2 R3 R6 R8 covered by the model
        enable = '1;
        for (int n = 0; n < 600; n++) begin
            pin_level = {$urandom(), $urandom()};
            if ($urandom_range(0, 7) == 0) polarity = $urandom();
            if ($urandom_range(0, 7) == 0) enable = $urandom();
            if ($urandom_range(0, 5) == 0) begin
                clr_wr = 3'($urandom());
                clr_data = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h00;
            end
            cycle("RAND");
        end
        // Reset mid-run returns to zero
        rst_n = 0; cycle("R12 rerun");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule